// File: doc/BRIEF.md
# DDR I/Q Sample Deinterleaver

This block takes one parallel sample bus that carries in-phase (I) and quadrature (Q) words, one word per edge of a single data clock. A word is captured on the rising edge and another on the falling edge. The block joins each two-word group into one I/Q pair and presents both samples together in the rising-edge domain, one pair per clock period. A `valid_out` strobe marks each cycle in which a fresh pair is on the outputs.

Two static controls set the bus timing. `i_first` says whether the I word or the Q word leads each group. `i_on_rise` says whether the I word is the one captured on the rising edge; Q then takes the other edge. Together they give four capture timings. A third control, `twos_in`, declares the input coding. The outputs are always two's complement, so offset-binary input is converted by flipping its top bit. The sample width is the parameter `SAMPLE_W`. Only 8, 10, 12 and 14 are accepted, and any other value stops elaboration.

Top module: `ddr_iq_deint`

## Requirements
- R1: While `rst_n` is low, `i_out`, `q_out` and `valid_out` are zero. After release, `valid_out` stays low through the first two rising edges that see `rst_n` high and can first be high after the third.
- R2: With `i_first`=1 and `i_on_rise`=1, a pair is the word captured on a rising edge followed by the word captured on the next falling edge. The rising word is I.
- R3: With `i_first`=0 and `i_on_rise`=1, a pair is a falling-edge word followed by the word on the next rising edge. The falling word is Q and the rising word is I.
- R4: With `i_first`=1 and `i_on_rise`=0, a pair is a falling-edge word followed by the word on the next rising edge. The falling word is I and the rising word is Q.
- R5: With `i_first`=0 and `i_on_rise`=0, a pair is a rising-edge word followed by the word on the next falling edge. The rising word is Q and the falling word is I.
- R6: The pair that contains the word captured on rising edge e appears on `i_out`/`q_out` right after rising edge e+1. With the mode held constant, one new pair is presented on every rising edge.
- R7: With `twos_in`=1, each output word equals its bus word bit for bit.
- R8: With `twos_in`=0, each output word equals its bus word with bit `SAMPLE_W`-1 inverted. Offset-binary zero therefore becomes the most negative code, and the mid code (top bit only) becomes zero.
- R9: When `{i_first,i_on_rise}` sampled at a rising edge differs from its value at the previous edge, `valid_out` is low after that edge. It returns high at the next edge if the mode is then unchanged.
- R10: A change of `twos_in` does not drop `valid_out`. It applies to the pair emitted on the rising edge where it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; words are captured on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | SAMPLE_W | Interleaved I/Q word bus |
| i_first | input | 1 | 1: I word leads each group; 0: Q word leads |
| i_on_rise | input | 1 | 1: I word is captured on the rising edge; 0: on the falling edge |
| twos_in | input | 1 | 1: input is two's complement; 0: input is offset binary |
| i_out | output | SAMPLE_W | In-phase sample, two's complement |
| q_out | output | SAMPLE_W | Quadrature sample, two's complement |
| valid_out | output | 1 | High in each cycle that presents a new pair |

## Verification
Every bus word is distinct and derived from a scenario seed and the word's position. A pair taken from the wrong edge, the wrong group or in swapped order therefore shows a different value. Each of the four timing modes is run with such sequences. The modes with the lead word on the falling edge are the ones that separate a correct one-group look-back from an off-by-one-edge pairing. Corner words (all zeros, all ones, top bit only, all but the top bit) are run with both codings, which distinguishes a top-bit flip from a full inversion or from no conversion. A run with the mode toggling on every edge, and one with only the coding toggling, tell apart the valid-drop rule for timing changes and the no-drop rule for coding changes.

// File: rtl/ddr_iq_pkg.sv
package ddr_iq_pkg;

    // Static capture-timing selection
    typedef struct packed {
        logic i_first;
        logic i_on_rise;
    } iq_mode_t;

    // Which clock edge carries the leading word of a group
    typedef enum logic {
        LEAD_RISE = 1'b0,
        LEAD_FALL = 1'b1
    } lead_e;

    localparam int unsigned FILL_W    = 2;
    localparam logic [FILL_W-1:0] FILL_FULL = 2'd2;

    // The lead word sits on the rising edge exactly when the I word's
    // position and I word's edge agree (I first on rise, or Q first on rise).
    function automatic lead_e lead_of(input iq_mode_t m);
        return (m.i_first == m.i_on_rise) ? LEAD_RISE : LEAD_FALL;
    endfunction

endpackage

// File: rtl/ddr_iq_fall_cap.sv
module ddr_iq_fall_cap #(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] word_in,
    output logic [SAMPLE_W-1:0] word_q
);

    logic [SAMPLE_W-1:0] word_d;

    always_comb begin
        word_d = word_in;
    end

    // Falling-edge capture register; read by the rising-edge pairing stage
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/ddr_iq_fmt.sv
module ddr_iq_fmt #(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] word_in,
    input  logic                twos_in,
    output logic [SAMPLE_W-1:0] word_out
);

    localparam int unsigned TOP = SAMPLE_W - 1;

    // Offset binary to two's complement: flip the top bit only
    always_comb begin
        word_out      = word_in;
        word_out[TOP] = word_in[TOP] ^ ~twos_in;
    end

endmodule

// File: rtl/ddr_iq_pair.sv
module ddr_iq_pair
    import ddr_iq_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] bus_in,
    input  logic [SAMPLE_W-1:0] fall_w,
    input  iq_mode_t            mode_in,
    input  logic                twos_in,
    output logic [SAMPLE_W-1:0] i_out,
    output logic [SAMPLE_W-1:0] q_out,
    output logic                valid_out
);

    localparam int unsigned LANES = 2;   // lane 0 = I, lane 1 = Q

    typedef struct packed {
        logic [SAMPLE_W-1:0] rise_w;    // word from the last rising edge
        logic [SAMPLE_W-1:0] fall_old;  // falling word before rise_w
        iq_mode_t            mode;      // mode seen at the last edge
        logic [FILL_W-1:0]   fill;      // edges since reset, saturating
        logic [SAMPLE_W-1:0] i_w;
        logic [SAMPLE_W-1:0] q_w;
        logic                vld;
    } pair_st_t;

    pair_st_t st_d, st_q;

    logic [LANES-1:0][SAMPLE_W-1:0] raw_w;
    logic [LANES-1:0][SAMPLE_W-1:0] cooked_w;
    logic [SAMPLE_W-1:0]            lead_w;
    logic [SAMPLE_W-1:0]            trail_w;

    // Group selection from the held rising word and the two falling words
    always_comb begin
        if (lead_of(mode_in) == LEAD_RISE) begin
            lead_w  = st_q.rise_w;
            trail_w = fall_w;
        end else begin
            lead_w  = st_q.fall_old;
            trail_w = st_q.rise_w;
        end
        raw_w[0] = mode_in.i_first ? lead_w  : trail_w;
        raw_w[1] = mode_in.i_first ? trail_w : lead_w;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddr_iq_fmt #(
            .SAMPLE_W (SAMPLE_W)
        ) u_fmt (
            .word_in  (raw_w[g]),
            .twos_in  (twos_in),
            .word_out (cooked_w[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rise_w   = bus_in;
        st_d.fall_old = fall_w;
        st_d.mode     = mode_in;
        st_d.fill     = (st_q.fill == FILL_FULL) ? FILL_FULL
                                                 : st_q.fill + {{(FILL_W-1){1'b0}}, 1'b1};
        st_d.vld      = (st_q.fill == FILL_FULL) && (mode_in == st_q.mode);
        if (st_d.vld) begin
            st_d.i_w = cooked_w[0];
            st_d.q_w = cooked_w[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_out     = st_q.i_w;
    assign q_out     = st_q.q_w;
    assign valid_out = st_q.vld;

endmodule

// File: rtl/ddr_iq_deint.sv
module ddr_iq_deint
    import ddr_iq_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] bus_in,
    input  logic                i_first,
    input  logic                i_on_rise,
    input  logic                twos_in,
    output logic [SAMPLE_W-1:0] i_out,
    output logic [SAMPLE_W-1:0] q_out,
    output logic                valid_out
);

    if (!(SAMPLE_W == 8 || SAMPLE_W == 10 || SAMPLE_W == 12 || SAMPLE_W == 14)) begin : g_bad_width
        $error("ddr_iq_deint: SAMPLE_W must be 8, 10, 12 or 14");
    end

    iq_mode_t            mode_in;
    logic [SAMPLE_W-1:0] fall_w;

    always_comb begin
        mode_in.i_first   = i_first;
        mode_in.i_on_rise = i_on_rise;
    end

    ddr_iq_fall_cap #(
        .SAMPLE_W (SAMPLE_W)
    ) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (bus_in),
        .word_q  (fall_w)
    );

    ddr_iq_pair #(
        .SAMPLE_W (SAMPLE_W)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .fall_w    (fall_w),
        .mode_in   (mode_in),
        .twos_in   (twos_in),
        .i_out     (i_out),
        .q_out     (q_out),
        .valid_out (valid_out)
    );

endmodule

// File: rtl/ddr_iq_deint_chk.sv
module ddr_iq_deint_chk #(
    parameter int unsigned SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] bus_in,
    input logic                i_first,
    input logic                i_on_rise,
    input logic                twos_in,
    input logic [SAMPLE_W-1:0] i_out,
    input logic [SAMPLE_W-1:0] q_out,
    input logic                valid_out
);

    localparam logic [SAMPLE_W-1:0] TOP_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 2'd0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    // R1
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd3) |-> !valid_out);

    // R9
    mode_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({i_first, i_on_rise} != $past({i_first, i_on_rise})) |=> !valid_out);

    // R10
    steady_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && {i_first, i_on_rise} == $past({i_first, i_on_rise})) |=> valid_out);

    // R2
    rise_i_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(i_first && i_on_rise && twos_in)) |-> (i_out == $past(bus_in, 2)));

    // R5
    rise_q_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(!i_first && !i_on_rise && twos_in)) |-> (q_out == $past(bus_in, 2)));

    // R8
    offset_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(i_first && i_on_rise && !twos_in)) |-> ((i_out ^ $past(bus_in, 2)) == TOP_MASK));

endmodule

bind ddr_iq_deint ddr_iq_deint_chk #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_in    (bus_in),
    .i_first   (i_first),
    .i_on_rise (i_on_rise),
    .twos_in   (twos_in),
    .i_out     (i_out),
    .q_out     (q_out),
    .valid_out (valid_out)
);

// File: tb/sim_ddr_iq_deint.sv
module sim_ddr_iq_deint;

    localparam int W = 12;
    localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic         i_first = 1'b0;
    logic         i_on_rise = 1'b0;
    logic         twos_in = 1'b1;
    logic [W-1:0] i_out;
    logic [W-1:0] q_out;
    logic         valid_out;

    always #5 clk = ~clk;

    ddr_iq_deint #(
        .SAMPLE_W (W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .i_first   (i_first),
        .i_on_rise (i_on_rise),
        .twos_in   (twos_in),
        .i_out     (i_out),
        .q_out     (q_out),
        .valid_out (valid_out)
    );

    int total = 0;
    int bad   = 0;

    // Bench-side model of what has been put on the bus
    logic [W-1:0] cur_r;      // word on the bus for the next rising edge
    logic [W-1:0] h_r;        // word taken at the last rising edge
    logic [W-1:0] h_f;        // falling word after h_r
    logic [W-1:0] h_fp;       // falling word before h_r
    logic [1:0]   mode_prev;
    int           edges;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] gen(input int s, input int k);
        int v;
        v = s * 97 + k * 53 + k * k * 7 + 11;
        return v[W-1:0];
    endfunction

    // One clock period: check the result of this rising edge, then drive
    // the falling word and the next rising word.
    task automatic step(input logic [W-1:0] fw, input logic [W-1:0] rnext, input string req);
        logic [W-1:0] lead_w, trail_w, ei, eq;
        bit           chg, ev;
        @(posedge clk);
        edges++;
        chg = ({i_first, i_on_rise} != mode_prev);
        if (i_first == i_on_rise) begin
            lead_w = h_r;  trail_w = h_f;
        end else begin
            lead_w = h_fp; trail_w = h_r;
        end
        ei = i_first ? lead_w : trail_w;
        eq = i_first ? trail_w : lead_w;
        if (!twos_in) begin
            ei = ei ^ TOPBIT;
            eq = eq ^ TOPBIT;
        end
        ev = (edges >= 3) && !chg;
        h_fp = h_f;
        h_r  = cur_r;
        mode_prev = {i_first, i_on_rise};
        #1;
        check(valid_out == ev, req, "valid_out", {{(W-1){1'b0}}, valid_out}, {{(W-1){1'b0}}, ev});
        if (ev) begin
            check(i_out == ei, req, "i_out", i_out, ei);
            check(q_out == eq, req, "q_out", q_out, eq);
        end
        #1.5;
        bus_in = fw;
        h_f = fw;
        @(negedge clk);
        #2.5;
        bus_in = rnext;
        cur_r = rnext;
    endtask

    task automatic do_reset(input string req);
        rst_n = 1'b0;
        bus_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check(valid_out == 1'b0, req, "valid_out in reset", {{(W-1){1'b0}}, valid_out}, '0);
        check(i_out == '0, req, "i_out in reset", i_out, '0);
        check(q_out == '0, req, "q_out in reset", q_out, '0);
        @(negedge clk);
        #2.5;
        rst_n = 1'b1;
        edges = 0;
        mode_prev = 2'b00;
        h_r = '0; h_f = '0; h_fp = '0;
        cur_r = gen(99, 0);
        bus_in = cur_r;
    endtask

    task automatic run_mode(input string req, input bit f, input bit r, input bit tw,
                            input int s, input int n);
        i_first = f;
        i_on_rise = r;
        twos_in = tw;
        for (int k = 0; k < n; k++) begin
            step(gen(s, 2 * k + 1), gen(s, 2 * k + 2), req);
        end
    endtask

    task automatic corner_words(input string req, input bit tw);
        logic [W-1:0] pat [4];
        pat[0] = '0;
        pat[1] = '1;
        pat[2] = TOPBIT;
        pat[3] = ~TOPBIT;
        i_first = 1'b1;
        i_on_rise = 1'b1;
        twos_in = tw;
        for (int k = 0; k < 8; k++) begin
            step(pat[(k + 1) % 4], pat[(k + 2) % 4], req);
        end
    endtask

    task automatic mode_toggle(input string req);
        twos_in = 1'b1;
        for (int k = 0; k < 8; k++) begin
            i_first = k[0];
            i_on_rise = k[1];
            step(gen(40, 2 * k + 1), gen(40, 2 * k + 2), req);
        end
    endtask

    task automatic twos_toggle(input string req);
        i_first = 1'b0;
        i_on_rise = 1'b1;
        for (int k = 0; k < 8; k++) begin
            twos_in = k[0];
            step(gen(50, 2 * k + 1), gen(50, 2 * k + 2), req);
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset("R1");
        run_mode("R1", 1'b1, 1'b1, 1'b1, 1, 4);
        run_mode("R2", 1'b1, 1'b1, 1'b1, 2, 10);
        run_mode("R3", 1'b0, 1'b1, 1'b1, 3, 10);
        run_mode("R4", 1'b1, 1'b0, 1'b1, 4, 10);
        run_mode("R5", 1'b0, 1'b0, 1'b1, 5, 10);
        run_mode("R6", 1'b1, 1'b0, 1'b1, 6, 6);
        run_mode("R7", 1'b0, 1'b1, 1'b1, 7, 6);
        run_mode("R8", 1'b0, 1'b0, 1'b0, 8, 8);
        run_mode("R8", 1'b1, 1'b0, 1'b0, 9, 8);
        corner_words("R8", 1'b0);
        corner_words("R7", 1'b1);
        mode_toggle("R9");
        run_mode("R9", 1'b1, 1'b1, 1'b1, 10, 4);
        twos_toggle("R10");
        do_reset("R1");
        run_mode("R1", 1'b0, 1'b0, 1'b1, 11, 5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule